// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block keeps wall-clock time as an unsigned count of seconds. An internal divider turns the system clock into one update pulse per second; on each pulse the seconds count steps forward by one. Software sets the time by writing a new value that is adopted at the next update pulse. Software also programs an alarm value that is compared against the count.

When an update produces a count equal to the alarm value, a pending flag is latched. The interrupt line is that flag qualified by an enable bit and a mask bit in the control register. Software sees the flag directly through a raw status word and in qualified form through a status word. It acknowledges the alarm by reading a dedicated acknowledge address. The register port is a plain synchronous bus with one address, separate read and write strobes and registered read data. Transfers are always accepted, so there is no back-pressure and no handshake.

Register word offsets (bytes): 0x00 current seconds, 0x04 alarm value, 0x08 time-set value, 0x0C control, 0x10 qualified status, 0x14 raw status, 0x18 acknowledge, 0x1C identification. Control bits: bit 0 interrupt enable, bit 1 interrupt mask, bit 2 run, bit 3 roll-over permit.

Top module: `rtcsec_top`

## Requirements
- R1: After reset, the words at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read zero, and `irq` is low.
- R2: The seconds count at 0x00 advances by one every TICKS_PER_SEC clock cycles, but only while control bit 2 is set. The divider restarts from zero whenever bit 2 is clear. The first update comes TICKS_PER_SEC cycles after the write that sets bit 2, and the count is frozen while bit 2 is clear.
- R3: A write to 0x08 leaves 0x00 unchanged until the next update pulse. That pulse replaces the count with the written value, without adding one.
- R4: On an update pulse at count 2^DATA_W-1, the count becomes 0 if control bit 3 is set. Otherwise it stays at 2^DATA_W-1.
- R5: An update pulse that makes the count equal to the word at 0x04 sets the raw pending flag (bit 0 of 0x14), whatever the enable and mask bits are. The flag stays set until it is acknowledged.
- R6: `irq` and bit 0 of 0x10 are high exactly when the raw flag is set, control bit 0 is set and control bit 1 is clear.
- R7: A read of 0x18 clears the raw pending flag. A write to 0x18 leaves it set.
- R8: If a read of 0x18 falls in the same cycle as a match-producing update, the flag stays set.
- R9: Address 0x1C reads the VERSION parameter. Writes to 0x00, 0x10, 0x14 and 0x1C change nothing. Address 0x08 reads zero, and any address outside the eight word offsets reads zero.
- R10: `bus_rd_data` shows the addressed word on the clock edge that samples `bus_rd_en`, and it holds that value until the next read.
- R11: Address 0x0C reads back control bits 3:0 with all upper bits zero, and address 0x04 reads back the full written alarm value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | DATA_W | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The hardest case to produce from the ports is an acknowledge read that lands on exactly the same edge as a match-producing update. The roll-over at the top of the count is nearly as hard. The bench shortens the divider to four cycles and keeps an edge counter of its own, and every divider restart is caused by a control write whose edge the bench records. It then presets the count through the time-set word so that the match or the top value arrives one or two updates later. The acknowledge read or the control write is placed on the computed edge.

// File: rtl/rtcsec_pkg.sv
package rtcsec_pkg;
  // Byte offsets of the register words
  localparam int unsigned OFS_COUNT = 'h00;
  localparam int unsigned OFS_MATCH = 'h04;
  localparam int unsigned OFS_LOAD  = 'h08;
  localparam int unsigned OFS_CTRL  = 'h0C;
  localparam int unsigned OFS_STAT  = 'h10;
  localparam int unsigned OFS_RAW   = 'h14;
  localparam int unsigned OFS_ACK   = 'h18;
  localparam int unsigned OFS_IDENT = 'h1C;

  localparam int unsigned CTRL_W = 4;

  // Control word, packed so that bit 0 is ie and bit 3 is wrap
  typedef struct packed {
    logic wrap;
    logic run;
    logic mask;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/rtcsec_prescaler.sv
module rtcsec_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] pcnt;

  assign tick = run && (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run || tick)   pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/rtcsec_counter.sv
module rtcsec_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrap_en,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] match_val,
  input  logic              ack_rd,
  output logic [DATA_W-1:0] count,
  output logic              ld_pend,
  output logic [DATA_W-1:0] ld_val,
  output logic              match_evt,
  output logic              raw_pend
);
  localparam logic [DATA_W-1:0] TOP = '1;

  logic [DATA_W-1:0] cnt_nxt;

  always_comb begin
    if (ld_pend)           cnt_nxt = ld_val;
    else if (count == TOP) cnt_nxt = wrap_en ? '0 : TOP;
    else                   cnt_nxt = count + 1'b1;
  end

  assign match_evt = tick && (cnt_nxt == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ld_pend  <= 1'b0;
      ld_val   <= '0;
      raw_pend <= 1'b0;
    end else begin
      if (tick) count <= cnt_nxt;
      // a value written on an update edge waits for the following update
      if (load_wr) begin
        ld_pend <= 1'b1;
        ld_val  <= load_data;
      end else if (tick) begin
        ld_pend <= 1'b0;
      end
      if (match_evt)   raw_pend <= 1'b1;
      else if (ack_rd) raw_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rtcsec_regs.sv
module rtcsec_regs
  import rtcsec_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 6,
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = 'h0001_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  input  logic [DATA_W-1:0] count,
  input  logic              raw_pend,
  input  logic              irq_lvl,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] match_val,
  output logic              load_wr,
  output logic [DATA_W-1:0] load_data,
  output logic              ack_rd,
  output logic [DATA_W-1:0] bus_rd_data
);
  logic sel_match, sel_ctrl;
  logic [DATA_W-1:0] rd_mux;

  assign sel_match = (bus_addr == ADDR_W'(OFS_MATCH));
  assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign load_wr   = bus_wr_en && (bus_addr == ADDR_W'(OFS_LOAD));
  assign load_data = bus_wr_data;
  assign ack_rd    = bus_rd_en && (bus_addr == ADDR_W'(OFS_ACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      match_val <= '0;
    end else if (bus_wr_en) begin
      if (sel_ctrl)  ctrl      <= ctrl_t'(bus_wr_data[CTRL_W-1:0]);
      if (sel_match) match_val <= bus_wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_COUNT): rd_mux = count;
      ADDR_W'(OFS_MATCH): rd_mux = match_val;
      ADDR_W'(OFS_CTRL):  rd_mux = DATA_W'(ctrl);
      ADDR_W'(OFS_STAT):  rd_mux = DATA_W'(irq_lvl);
      ADDR_W'(OFS_RAW):   rd_mux = DATA_W'(raw_pend);
      ADDR_W'(OFS_IDENT): rd_mux = VERSION;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rd_data <= '0;
    else if (bus_rd_en) bus_rd_data <= rd_mux;
  end
endmodule

// File: rtl/rtcsec_top.sv
module rtcsec_top
  import rtcsec_pkg::*;
#(
  parameter int unsigned       TICKS_PER_SEC = 32768,
  parameter int unsigned       ADDR_W        = 6,
  parameter int unsigned       DATA_W        = 32,
  parameter logic [DATA_W-1:0] VERSION       = 'h0001_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              irq
);
  ctrl_t             ctrl;
  logic              tick;
  logic [DATA_W-1:0] match_val;
  logic              load_wr;
  logic [DATA_W-1:0] load_data;
  logic              ack_rd;
  logic [DATA_W-1:0] count;
  logic              ld_pend;
  logic [DATA_W-1:0] ld_val;
  logic              match_evt;
  logic              raw_pend;
  logic              irq_lvl;

  assign irq_lvl = raw_pend && ctrl.ie && !ctrl.mask;
  assign irq     = irq_lvl;

  rtcsec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick)
  );

  rtcsec_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap_en(ctrl.wrap),
    .load_wr(load_wr), .load_data(load_data), .match_val(match_val),
    .ack_rd(ack_rd), .count(count), .ld_pend(ld_pend), .ld_val(ld_val),
    .match_evt(match_evt), .raw_pend(raw_pend)
  );

  rtcsec_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .count(count),
    .raw_pend(raw_pend), .irq_lvl(irq_lvl), .ctrl(ctrl),
    .match_val(match_val), .load_wr(load_wr), .load_data(load_data),
    .ack_rd(ack_rd), .bus_rd_data(bus_rd_data)
  );
endmodule

// File: rtl/rtcsec_chk.sv
module rtcsec_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run,
  input logic              wrap_en,
  input logic              ie,
  input logic              mask,
  input logic              ld_pend,
  input logic [DATA_W-1:0] ld_val,
  input logic [DATA_W-1:0] count,
  input logic              match_evt,
  input logic              ack_rd,
  input logic              raw_pend,
  input logic              irq
);
  localparam logic [DATA_W-1:0] TOP = '1;

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_pend && count != TOP) |=> count == DATA_W'($past(count) + 1'b1)); // R2
  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ld_pend) |=> count == $past(ld_val)); // R3
  AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count)); // R3
  AST_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_pend && count == TOP && !wrap_en) |=> count == TOP); // R4
  AST_TOP_ROLLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_pend && count == TOP && wrap_en) |=> count == '0); // R4
  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> raw_pend); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !match_evt) |=> !raw_pend); // R7
  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie || mask) |-> !irq); // R6
endmodule

bind rtcsec_top rtcsec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.run), .wrap_en(ctrl.wrap),
  .ie(ctrl.ie), .mask(ctrl.mask), .ld_pend(ld_pend), .ld_val(ld_val),
  .count(count), .match_evt(match_evt), .ack_rd(ack_rd),
  .raw_pend(raw_pend), .irq(irq)
);

// File: tb/tb_rtcsec_top.sv
module tb_rtcsec_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;
  localparam int AW         = 6;
  localparam int DW         = 32;
  localparam logic [DW-1:0] VER = 32'h0001_0002;
  localparam logic [DW-1:0] TOPV = '1;

  localparam int A_CNT = 'h00, A_MAT = 'h04, A_LD = 'h08, A_CTL = 'h0C;
  localparam int A_ST = 'h10, A_RAW = 'h14, A_ACK = 'h18, A_VER = 'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [DW-1:0] bus_wr_data = '0;
  logic          bus_rd_en = 1'b0;
  logic [DW-1:0] bus_rd_data;
  logic          irq;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  rtcsec_top #(.TICKS_PER_SEC(TPS), .ADDR_W(AW), .DATA_W(DW), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_edge(input int edge_no);
    if (cyc + 1 > edge_no) chk("schedule", DW'(cyc + 1), DW'(edge_no));
    while (cyc + 1 < edge_no) @(negedge clk);
  endtask

  task automatic bus_wr(input int addr, input logic [DW-1:0] data, output int edge_no);
    bus_addr = AW'(addr); bus_wr_data = data; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    edge_no = cyc;
  endtask

  task automatic bus_rd(input int addr, output logic [DW-1:0] data);
    bus_addr = AW'(addr); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    data = bus_rd_data;
  endtask

  task automatic rd_at(input int addr, input int edge_no, output logic [DW-1:0] data);
    wait_edge(edge_no);
    bus_rd(addr, data);
  endtask

  task automatic wr_at(input int addr, input logic [DW-1:0] d, input int edge_no);
    int e;
    wait_edge(edge_no);
    bus_wr(addr, d, e);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    bus_rd(A_CNT, d); chk("R1 count", d, 0);
    bus_rd(A_MAT, d); chk("R1 match", d, 0);
    bus_rd(A_LD,  d); chk("R1 load", d, 0);
    bus_rd(A_CTL, d); chk("R1 ctrl", d, 0);
    bus_rd(A_ST,  d); chk("R1 status", d, 0);
    bus_rd(A_RAW, d); chk("R1 raw", d, 0);
    chk("R1 irq", DW'(irq), 0);
  endtask

  int last_count;

  task automatic t_count();
    int e, d_e;
    logic [DW-1:0] d, a, b;
    bus_wr(A_CTL, 32'h4, e);
    rd_at(A_CNT, e + 4, d);  chk("R2 first update not before edge", d, 0);
    rd_at(A_CNT, e + 10, d); chk("R2 count after 10", d, 2);
    rd_at(A_CNT, e + 13, d); chk("R2 count after 13", d, 3);
    repeat (3) @(negedge clk);
    bus_wr(A_CTL, 32'h0, d_e);
    bus_rd(A_CNT, a); chk("R2 count at halt", a, DW'((d_e - e) / TPS));
    repeat (12) @(negedge clk);
    bus_rd(A_CNT, b); chk("R2 frozen while halted", b, a);
    last_count = int'(a);
  endtask

  task automatic t_load();
    int e, dummy;
    logic [DW-1:0] d;
    bus_wr(A_LD, 32'd100, dummy);
    bus_wr(A_CTL, 32'h4, e);
    rd_at(A_CNT, e + 3, d); chk("R3 load deferred", d, DW'(last_count));
    rd_at(A_CNT, e + 5, d); chk("R3 load taken at update", d, 100);
    rd_at(A_CNT, e + 9, d); chk("R3 counts on from load", d, 101);
    bus_wr(A_CTL, 32'h0, dummy);
  endtask

  task automatic t_wrap();
    int e, dummy;
    logic [DW-1:0] d;
    bus_wr(A_LD, TOPV, dummy);
    bus_wr(A_CTL, 32'h4, e);
    rd_at(A_CNT, e + 10, d); chk("R4 holds at top without permit", d, TOPV);
    wr_at(A_CTL, 32'hC, e + 11);
    rd_at(A_CNT, e + 14, d); chk("R4 rolls to zero with permit", d, 0);
    rd_at(A_RAW, e + 15, d); chk("R5 match at zero latched with ie clear", d, 1);
    bus_wr(A_CTL, 32'h0, dummy);
  endtask

  task automatic t_match();
    int e, dummy;
    logic [DW-1:0] d;
    bus_rd(A_ACK, d);
    bus_rd(A_RAW, d); chk("R7 ack read clears", d, 0);
    bus_wr(A_MAT, 32'd50, dummy);
    bus_wr(A_LD, 32'd48, dummy);
    bus_wr(A_CTL, 32'h4, e);
    rd_at(A_RAW, e + 10, d); chk("R5 no flag before match", d, 0);
    rd_at(A_RAW, e + 13, d); chk("R5 flag after match", d, 1);
    chk("R6 irq low with ie clear", DW'(irq), 0);
    bus_wr(A_CTL, 32'h0, dummy);
    bus_wr(A_CTL, 32'h1, dummy);
    chk("R6 irq high when enabled", DW'(irq), 1);
    bus_rd(A_ST, d); chk("R6 status high", d, 1);
    bus_wr(A_CTL, 32'h3, dummy);
    chk("R6 irq masked", DW'(irq), 0);
    bus_rd(A_ST, d); chk("R6 status masked", d, 0);
    bus_rd(A_RAW, d); chk("R5 raw ignores mask", d, 1);
    bus_wr(A_ACK, TOPV, dummy);
    bus_rd(A_RAW, d); chk("R7 ack write has no effect", d, 1);
    bus_wr(A_CTL, 32'h1, dummy);
    chk("R6 irq back on unmask", DW'(irq), 1);
    bus_rd(A_ACK, d);
    chk("R7 irq drops after ack read", DW'(irq), 0);
    bus_rd(A_RAW, d); chk("R7 raw clear after ack read", d, 0);
    bus_wr(A_CTL, 32'h0, dummy);
  endtask

  task automatic t_collide();
    int e, dummy;
    logic [DW-1:0] d;
    bus_wr(A_LD, 32'd199, dummy);
    bus_wr(A_MAT, 32'd200, dummy);
    bus_wr(A_CTL, 32'h5, e);
    rd_at(A_ACK, e + 8, d);
    chk("R8 irq stays on collision", DW'(irq), 1);
    bus_rd(A_RAW, d); chk("R8 raw stays on collision", d, 1);
    rd_at(A_ACK, e + 10, d);
    chk("R7 later ack clears", DW'(irq), 0);
    bus_wr(A_CTL, 32'h0, dummy);
  endtask

  task automatic t_ro();
    int dummy;
    logic [DW-1:0] c0, d;
    bus_rd(A_CNT, c0);
    bus_wr(A_CNT, TOPV, dummy);
    bus_wr(A_ST,  TOPV, dummy);
    bus_wr(A_RAW, TOPV, dummy);
    bus_wr(A_VER, TOPV, dummy);
    bus_rd(A_CNT, d); chk("R9 count not writable", d, c0);
    bus_rd(A_RAW, d); chk("R9 raw not writable", d, 0);
    bus_rd(A_ST,  d); chk("R9 status not writable", d, 0);
    bus_rd(A_LD,  d); chk("R9 load reads zero", d, 0);
    bus_rd(A_VER, d); chk("R9 version", d, VER);
    repeat (5) @(negedge clk);
    chk("R10 read data holds", bus_rd_data, VER);
    bus_rd('h24, d); chk("R9 unmapped reads zero", d, 0);
    bus_rd('h02, d); chk("R9 unaligned reads zero", d, 0);
    bus_wr(A_CTL, 32'hFFFF_FFFA, dummy);
    bus_rd(A_CTL, d); chk("R11 ctrl readback", d, 32'hA);
    bus_wr(A_MAT, 32'hDEAD_BEEF, dummy);
    bus_rd(A_MAT, d); chk("R11 match readback", d, 32'hDEAD_BEEF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_load();
    t_wrap();
    t_match();
    t_collide();
    t_ro();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule